// File: doc/BRIEF.md
# Segment-Mapped Address Translation Front End

This block sits in front of a page-table lookup engine and decides, for each memory access, how its 32-bit virtual address becomes a physical one. A request carries the virtual address, an access kind (read, write or execute) and a flag that marks user-mode accesses. Three outcomes are possible. When address translation is switched off, the address is returned unchanged with every permission granted. When translation is on and a kernel access falls in a 256 MB segment that is configured for direct mapping, the upper four address bits are replaced by a per-segment base nibble, taken from one of two kernel-base registers. All remaining accesses are forwarded to the lookup port, and the lookup's answer is handed back unchanged.

The configuration registers are plain inputs and are sampled in the cycle the request is accepted. A small state machine tracks the lookup: ST_IDLE accepts requests (transition IDLE->ISSUE on a request that needs a lookup; a bypassed request stays in IDLE), ST_ISSUE drives the one-cycle lookup strobe (ISSUE->IDLE when the answer arrives in that same cycle, ISSUE->WAIT otherwise), and ST_WAIT waits for the answer (WAIT->IDLE when it arrives). The front end is ready only in ST_IDLE.

Top module: `vaddr_route_unit`

## Requirements
- R1: With translation disabled, the result one cycle after an accepted request has out_paddr equal to req_vaddr, out_perm = 3'b111 (bit 0 read, bit 1 write, bit 2 execute) and out_miss = 0, and no lookup is issued.
- R2: Translation is enabled when bit 2 or bit 3 of cfg_global is 1 and disabled when both are 0; every other bit of cfg_global has no effect.
- R3: With translation enabled, a request with req_user = 0 whose segment (req_vaddr[31:28]) has its bit set in cfg_segmap is direct-mapped: the result one cycle later has out_perm = 3'b111 and out_miss = 0, and no lookup is issued.
- R4: A direct-mapped physical address is the base nibble in bits [31:28] followed by req_vaddr[27:0]; segments 0 to 7 take the nibble from cfg_kbase_lo and segments 8 to 15 from cfg_kbase_hi, at bits [4*(seg mod 8)+3 : 4*(seg mod 8)].
- R5: With translation enabled, a user-mode request (req_user = 1) is never direct-mapped and always goes to the lookup port.
- R6: With translation enabled, a kernel request whose segment bit in cfg_segmap is 0 goes to the lookup port.
- R7: A lookup is announced by lk_req high for exactly one cycle, the cycle after acceptance, with lk_vaddr, lk_kind and lk_user equal to the accepted request; lk_iside is 1 only for execute (req_kind = 2); read (0), write (1) and the spare code 3 go to the data unit (lk_iside = 0).
- R8: One cycle after lk_rsp_valid is sampled while a lookup is outstanding, out_valid is 1 with out_paddr, out_perm and out_miss equal to lk_rsp_paddr, lk_rsp_perm and lk_rsp_miss; lk_rsp_valid while no lookup is outstanding has no effect.
- R9: req_ready is 0 from the cycle after a lookup is issued until the cycle after its answer; a request offered meanwhile is dropped and produces neither a lookup nor a result.
- R10: Each accepted request gives exactly one out_valid pulse; back-to-back bypassed requests give results on consecutive cycles. After reset out_valid = 0, lk_req = 0 and req_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 treated as read |
| req_user | input | 1 | 1 for a user-mode access |
| cfg_global | input | 32 | Global configuration; bits 3:2 enable translation |
| cfg_segmap | input | 16 | One direct-map enable bit per segment |
| cfg_kbase_lo | input | 32 | Base nibbles for segments 0 to 7 |
| cfg_kbase_hi | input | 32 | Base nibbles for segments 8 to 15 |
| req_ready | output | 1 | Front end can accept a request |
| lk_req | output | 1 | One-cycle lookup request strobe |
| lk_vaddr | output | 32 | Address forwarded to the lookup |
| lk_kind | output | 2 | Access kind forwarded to the lookup |
| lk_user | output | 1 | User flag forwarded to the lookup |
| lk_iside | output | 1 | 1 selects the instruction unit, 0 the data unit |
| lk_rsp_valid | input | 1 | Lookup answer strobe |
| lk_rsp_paddr | input | 32 | Physical address from the lookup |
| lk_rsp_perm | input | 3 | Permissions from the lookup |
| lk_rsp_miss | input | 1 | Miss flag from the lookup |
| out_valid | output | 1 | Result strobe |
| out_paddr | output | 32 | Physical address |
| out_perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| out_miss | output | 1 | Translation miss |

## Verification
A bypassed request (disabled or direct-mapped) has its result on the first rising edge that samples it, so the bench drives on the falling edge and reads the result at the next falling edge. A request needing the page path shows lk_req and its fields after that same edge, and its result appears after the edge that samples lk_rsp_valid; the bench answers after zero to three idle cycles, offers a stray request in the first idle cycle, and checks one falling edge after each strobe, plus one cycle later to confirm the pulse has ended. The sweep covers every segment, both privilege levels, both segment-map settings and all four states of the two enable bits, with expected addresses computed from the base registers by shift and mask.

// File: rtl/vroute_pkg.sv
package vroute_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PATH_FLAT = 2'd0,
        PATH_SEG  = 2'd1,
        PATH_PAGE = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fsm_state_e;

    localparam int PERM_W = 3;
    localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;

    function automatic logic kind_is_exec(input logic [1:0] kind);
        return kind == 2'(ACC_EXEC);
    endfunction

endpackage

// File: rtl/vroute_seg_base.sv
module vroute_seg_base #(
    parameter  int SEG_BITS = 4,
    localparam int NUM_SEG  = 1 << SEG_BITS,
    localparam int HALF     = NUM_SEG / 2,
    localparam int BASE_W   = HALF * SEG_BITS
) (
    input  logic [BASE_W-1:0]   kbase_lo_i,
    input  logic [BASE_W-1:0]   kbase_hi_i,
    input  logic [SEG_BITS-1:0] seg_i,
    output logic [SEG_BITS-1:0] base_o
);

    logic [SEG_BITS-1:0] nib_tbl [NUM_SEG];

    // Lower half of the segment space reads the low register, upper half the high one.
    for (genvar g = 0; g < HALF; g++) begin : g_nib
        assign nib_tbl[g]        = kbase_lo_i[g*SEG_BITS +: SEG_BITS];
        assign nib_tbl[g + HALF] = kbase_hi_i[g*SEG_BITS +: SEG_BITS];
    end

    assign base_o = nib_tbl[seg_i];

endmodule

// File: rtl/vroute_classify.sv
module vroute_classify
    import vroute_pkg::*;
#(
    parameter  int ADDR_W   = 32,
    parameter  int SEG_BITS = 4,
    parameter  int CTRL_W   = 32,
    parameter  int EN_LO    = 2,
    parameter  int EN_HI    = 3,
    localparam int NUM_SEG  = 1 << SEG_BITS,
    localparam int BASE_W   = (NUM_SEG / 2) * SEG_BITS,
    localparam int OFS_W    = ADDR_W - SEG_BITS
) (
    input  logic [ADDR_W-1:0]  vaddr_i,
    input  logic               user_i,
    input  logic [CTRL_W-1:0]  ctrl_i,
    input  logic [NUM_SEG-1:0] segmap_i,
    input  logic [BASE_W-1:0]  kbase_lo_i,
    input  logic [BASE_W-1:0]  kbase_hi_i,
    output route_e             route_o,
    output logic [ADDR_W-1:0]  bypass_paddr_o
);

    logic                xlate_on;
    logic [SEG_BITS-1:0] seg;
    logic [SEG_BITS-1:0] seg_base;
    logic                seg_direct;
    logic                unused_ctrl;

    assign xlate_on    = |ctrl_i[EN_HI:EN_LO];
    assign unused_ctrl = ^{ctrl_i[CTRL_W-1:EN_HI+1], ctrl_i[EN_LO-1:0]};
    assign seg         = vaddr_i[ADDR_W-1 -: SEG_BITS];
    assign seg_direct  = !user_i && segmap_i[seg];

    vroute_seg_base #(
        .SEG_BITS (SEG_BITS)
    ) u_seg_base (
        .kbase_lo_i (kbase_lo_i),
        .kbase_hi_i (kbase_hi_i),
        .seg_i      (seg),
        .base_o     (seg_base)
    );

    always_comb begin
        if (!xlate_on) begin
            route_o        = PATH_FLAT;
            bypass_paddr_o = vaddr_i;
        end else if (seg_direct) begin
            route_o        = PATH_SEG;
            bypass_paddr_o = {seg_base, vaddr_i[OFS_W-1:0]};
        end else begin
            route_o        = PATH_PAGE;
            bypass_paddr_o = vaddr_i;
        end
    end

endmodule

// File: rtl/vroute_ctrl.sv
module vroute_ctrl
    import vroute_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_vaddr_i,
    input  logic [1:0]        req_kind_i,
    input  logic              req_user_i,
    input  route_e            route_i,
    input  logic [ADDR_W-1:0] bypass_paddr_i,
    input  logic              rsp_valid_i,
    input  logic [ADDR_W-1:0] rsp_paddr_i,
    input  logic [PERM_W-1:0] rsp_perm_i,
    input  logic              rsp_miss_i,
    output logic              req_ready_o,
    output logic              lk_req_o,
    output logic [ADDR_W-1:0] lk_vaddr_o,
    output logic [1:0]        lk_kind_o,
    output logic              lk_user_o,
    output logic              lk_iside_o,
    output logic              out_valid_o,
    output logic [ADDR_W-1:0] out_paddr_o,
    output logic [PERM_W-1:0] out_perm_o,
    output logic              out_miss_o
);

    fsm_state_e state, state_nx;
    logic       accept;
    logic       rsp_take;

    assign accept   = (state == ST_IDLE) && req_valid_i;
    assign rsp_take = (state != ST_IDLE) && rsp_valid_i;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept && route_i == PATH_PAGE) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = rsp_valid_i ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (rsp_valid_i) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign req_ready_o = (state == ST_IDLE);
    assign lk_req_o    = (state == ST_ISSUE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_paddr_o <= '0;
            out_perm_o  <= '0;
            out_miss_o  <= 1'b0;
            lk_vaddr_o  <= '0;
            lk_kind_o   <= '0;
            lk_user_o   <= 1'b0;
            lk_iside_o  <= 1'b0;
        end else begin
            out_valid_o <= 1'b0;
            if (accept) begin
                if (route_i != PATH_PAGE) begin
                    out_valid_o <= 1'b1;
                    out_paddr_o <= bypass_paddr_i;
                    out_perm_o  <= PERM_ALL;
                    out_miss_o  <= 1'b0;
                end else begin
                    lk_vaddr_o  <= req_vaddr_i;
                    lk_kind_o   <= req_kind_i;
                    lk_user_o   <= req_user_i;
                    lk_iside_o  <= kind_is_exec(req_kind_i);
                end
            end
            if (rsp_take) begin
                out_valid_o <= 1'b1;
                out_paddr_o <= rsp_paddr_i;
                out_perm_o  <= rsp_perm_i;
                out_miss_o  <= rsp_miss_i;
            end
        end
    end

    // R7: the lookup strobe lasts a single cycle
    a_r7_lookup_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req_o |=> !lk_req_o);

    // R9: a page-path request issues a lookup and closes the front end
    a_r9_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && route_i == PATH_PAGE)
        |=> (lk_req_o && !req_ready_o && !out_valid_o));

    // R3: a bypassed request completes next cycle with full rights and no lookup
    a_r3_bypass_done: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && route_i != PATH_PAGE)
        |=> (out_valid_o && !out_miss_o && out_perm_o == PERM_ALL && !lk_req_o));

    // R8: the lookup answer is forwarded unchanged and the front end reopens
    a_r8_rsp_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && !req_ready_o)
        |=> (out_valid_o && req_ready_o
             && out_paddr_o == $past(rsp_paddr_i)
             && out_perm_o  == $past(rsp_perm_i)
             && out_miss_o  == $past(rsp_miss_i)));

    // R8: an answer while idle yields no result
    a_r8_idle_rsp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && req_ready_o && !req_valid_i) |=> !out_valid_o);

endmodule

// File: rtl/vaddr_route_unit.sv
module vaddr_route_unit
    import vroute_pkg::*;
#(
    parameter  int ADDR_W   = 32,
    parameter  int SEG_BITS = 4,
    parameter  int CTRL_W   = 32,
    parameter  int EN_LO    = 2,
    parameter  int EN_HI    = 3,
    localparam int NUM_SEG  = 1 << SEG_BITS,
    localparam int BASE_W   = (NUM_SEG / 2) * SEG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic [CTRL_W-1:0] cfg_global,
    input  logic [NUM_SEG-1:0] cfg_segmap,
    input  logic [BASE_W-1:0] cfg_kbase_lo,
    input  logic [BASE_W-1:0] cfg_kbase_hi,
    output logic              req_ready,
    output logic              lk_req,
    output logic [ADDR_W-1:0] lk_vaddr,
    output logic [1:0]        lk_kind,
    output logic              lk_user,
    output logic              lk_iside,
    input  logic              lk_rsp_valid,
    input  logic [ADDR_W-1:0] lk_rsp_paddr,
    input  logic [PERM_W-1:0] lk_rsp_perm,
    input  logic              lk_rsp_miss,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_paddr,
    output logic [PERM_W-1:0] out_perm,
    output logic              out_miss
);

    route_e            route;
    logic [ADDR_W-1:0] bypass_paddr;

    vroute_classify #(
        .ADDR_W   (ADDR_W),
        .SEG_BITS (SEG_BITS),
        .CTRL_W   (CTRL_W),
        .EN_LO    (EN_LO),
        .EN_HI    (EN_HI)
    ) u_classify (
        .vaddr_i        (req_vaddr),
        .user_i         (req_user),
        .ctrl_i         (cfg_global),
        .segmap_i       (cfg_segmap),
        .kbase_lo_i     (cfg_kbase_lo),
        .kbase_hi_i     (cfg_kbase_hi),
        .route_o        (route),
        .bypass_paddr_o (bypass_paddr)
    );

    vroute_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid_i    (req_valid),
        .req_vaddr_i    (req_vaddr),
        .req_kind_i     (req_kind),
        .req_user_i     (req_user),
        .route_i        (route),
        .bypass_paddr_i (bypass_paddr),
        .rsp_valid_i    (lk_rsp_valid),
        .rsp_paddr_i    (lk_rsp_paddr),
        .rsp_perm_i     (lk_rsp_perm),
        .rsp_miss_i     (lk_rsp_miss),
        .req_ready_o    (req_ready),
        .lk_req_o       (lk_req),
        .lk_vaddr_o     (lk_vaddr),
        .lk_kind_o      (lk_kind),
        .lk_user_o      (lk_user),
        .lk_iside_o     (lk_iside),
        .out_valid_o    (out_valid),
        .out_paddr_o    (out_paddr),
        .out_perm_o     (out_perm),
        .out_miss_o     (out_miss)
    );

    // R1: with both enable bits clear the address passes straight through
    a_r1_flat_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_global[EN_HI:EN_LO] == '0)
        |=> (out_valid && out_paddr == $past(req_vaddr)));

    // R5: an enabled user-mode request always reaches the lookup port
    a_r5_user_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_user && cfg_global[EN_HI:EN_LO] != '0)
        |=> (lk_req && lk_user));

    // R7: execute requests are steered to the instruction side
    a_r7_exec_iside: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_user && req_kind == 2'(ACC_EXEC)
         && cfg_global[EN_HI:EN_LO] != '0)
        |=> lk_iside);

endmodule

// File: tb/vaddr_route_unit_tb.sv
`timescale 1ns/1ps
module vaddr_route_unit_tb;

    localparam logic [31:0] KLO = 32'hA5C3_1E97;
    localparam logic [31:0] KHI = 32'h4B2F_D068;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        req_user;
    logic [31:0] cfg_global;
    logic [15:0] cfg_segmap;
    logic [31:0] cfg_kbase_lo;
    logic [31:0] cfg_kbase_hi;
    logic        req_ready;
    logic        lk_req;
    logic [31:0] lk_vaddr;
    logic [1:0]  lk_kind;
    logic        lk_user;
    logic        lk_iside;
    logic        lk_rsp_valid;
    logic [31:0] lk_rsp_paddr;
    logic [2:0]  lk_rsp_perm;
    logic        lk_rsp_miss;
    logic        out_valid;
    logic [31:0] out_paddr;
    logic [2:0]  out_perm;
    logic        out_miss;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vaddr_route_unit u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_vaddr (req_vaddr), .req_kind (req_kind), .req_user (req_user),
        .cfg_global (cfg_global), .cfg_segmap (cfg_segmap),
        .cfg_kbase_lo (cfg_kbase_lo), .cfg_kbase_hi (cfg_kbase_hi),
        .req_ready (req_ready), .lk_req (lk_req), .lk_vaddr (lk_vaddr), .lk_kind (lk_kind),
        .lk_user (lk_user), .lk_iside (lk_iside),
        .lk_rsp_valid (lk_rsp_valid), .lk_rsp_paddr (lk_rsp_paddr),
        .lk_rsp_perm (lk_rsp_perm), .lk_rsp_miss (lk_rsp_miss),
        .out_valid (out_valid), .out_paddr (out_paddr), .out_perm (out_perm), .out_miss (out_miss)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_one(input int en, input int seg, input int user, input int mb);
        logic [31:0] va, rsp_pa, exp_pa;
        logic [3:0]  nib;
        logic [1:0]  kind;
        logic [2:0]  rperm;
        logic        rmiss, flat, direct;
        int          delay;
        va     = {4'(seg), 28'(seg * 28'h0123457) ^ 28'h9ABCDEF};
        kind   = 2'((seg + user) % 4);
        flat   = (en == 0);
        direct = !flat && (user == 0) && (mb == 1);
        nib    = 4'(((seg < 8) ? KLO : KHI) >> (4 * (seg % 8)));
        exp_pa = flat ? va : {nib, va[27:0]};
        rsp_pa = va ^ 32'hF0F0_1234;
        rperm  = 3'(seg);
        rmiss  = 1'(seg) ^ 1'(user);
        delay  = (seg + mb) % 4;

        @(negedge clk);
        cfg_global = 32'h1234_5673 | (32'(en) << 2);
        cfg_segmap = (mb == 1) ? (16'h1 << seg) : ~(16'h1 << seg);
        req_vaddr  = va;
        req_kind   = kind;
        req_user   = 1'(user);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;

        if (flat || direct) begin
            chk(lk_req == 1'b0, "R2 no lookup on bypass", 32'(lk_req), 0);
            chk(out_valid == 1'b1, "R10 result strobe", 32'(out_valid), 1);
            if (flat) chk(out_paddr == exp_pa, "R1 flat address", out_paddr, exp_pa);
            else      chk(out_paddr == exp_pa, "R4 segment address", out_paddr, exp_pa);
            chk(out_perm == 3'b111 && !out_miss, flat ? "R1 full rights" : "R3 full rights",
                {28'(out_miss), 1'b0, out_perm}, 32'h7);
            @(negedge clk);
            chk(out_valid == 1'b0, "R10 single pulse", 32'(out_valid), 0);
        end else begin
            chk(lk_req == 1'b1, (user == 1) ? "R5 user to lookup" : "R6 unmapped to lookup",
                32'(lk_req), 1);
            chk(out_valid == 1'b0, "R2 no early result", 32'(out_valid), 0);
            chk(lk_vaddr == va && lk_kind == kind && lk_user == 1'(user), "R7 lookup fields",
                lk_vaddr, va);
            chk(lk_iside == (kind == 2'd2), "R7 unit select", 32'(lk_iside), 32'(kind == 2'd2));
            chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 0);
            for (int d = 0; d < delay; d++) begin
                req_valid = (d == 0);
                req_vaddr = va ^ 32'h1;
                @(negedge clk);
                req_valid = 1'b0;
                chk(lk_req == 1'b0 && out_valid == 1'b0 && req_ready == 1'b0,
                    "R9 request dropped while busy", {lk_req, out_valid, req_ready}, 0);
            end
            lk_rsp_valid = 1'b1;
            lk_rsp_paddr = rsp_pa;
            lk_rsp_perm  = rperm;
            lk_rsp_miss  = rmiss;
            @(negedge clk);
            lk_rsp_valid = 1'b0;
            chk(out_valid == 1'b1, "R8 result strobe", 32'(out_valid), 1);
            chk(out_paddr == rsp_pa, "R8 forwarded address", out_paddr, rsp_pa);
            chk(out_perm == rperm && out_miss == rmiss, "R8 forwarded rights",
                {28'(out_miss), out_perm}, {28'(rmiss), rperm});
            chk(req_ready == 1'b1, "R9 ready again", 32'(req_ready), 1);
            @(negedge clk);
            chk(out_valid == 1'b0, "R10 single pulse", 32'(out_valid), 0);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_user = 1'b0;
        cfg_global = '0; cfg_segmap = '0;
        cfg_kbase_lo = KLO; cfg_kbase_hi = KHI;
        lk_rsp_valid = 1'b0; lk_rsp_paddr = '0; lk_rsp_perm = '0; lk_rsp_miss = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && lk_req == 1'b0 && req_ready == 1'b1, "R10 reset state",
            {out_valid, lk_req, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int en = 0; en < 4; en++)
            for (int seg = 0; seg < 16; seg++)
                for (int user = 0; user < 2; user++)
                    for (int mb = 0; mb < 2; mb++)
                        run_one(en, seg, user, mb);

        // R8: answer while idle is ignored
        lk_rsp_valid = 1'b1;
        lk_rsp_paddr = 32'hDEAD_0000;
        @(negedge clk);
        lk_rsp_valid = 1'b0;
        chk(out_valid == 1'b0 && req_ready == 1'b1, "R8 idle answer ignored",
            {out_valid, req_ready}, 32'h1);

        // R10: back-to-back flat requests
        cfg_global = 32'hFFFF_FFF3;
        req_valid = 1'b1; req_vaddr = 32'h1357_9BDF;
        @(negedge clk);
        req_vaddr = 32'h2468_ACE0;
        chk(out_valid && out_paddr == 32'h1357_9BDF, "R10 first of pair", out_paddr, 32'h1357_9BDF);
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid && out_paddr == 32'h2468_ACE0, "R10 second of pair", out_paddr, 32'h2468_ACE0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 pair ends", 32'(out_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule